// File: doc/BRIEF.md
# Multiframe Channel Nibble Capture

This block sits in the receive path of a four-wire subscriber-line transceiver that runs with multiframing on. Upstream logic has already decoded the line and found frame alignment. For each received frame it supplies a frame strobe, and it marks the first frame of each multiframe with a start strobe. With every frame strobe it also supplies the bit that carries the multiframe channel. A multiframe is `NIB_W*GRP` frames long, which is 20 by default. One channel bit arrives in the first frame of each group of `GRP` frames. The block shifts these bits into a 4-bit nibble. At the end of the multiframe it copies the nibble into the upper field of an 8-bit status word.

When set to the network side, the block also checks the line. In the frames that carry no channel bit, the same bit position must be 0. The block raises a quality flag when this held for the whole multiframe. When set to the terminal side, the flag stays at 0.

A maskable interrupt request reports each capture. A policy input sets when it fires: after every completed multiframe, or only when the captured nibble differs from the one already held. A read strobe on the status word clears the pending request.

Top module: `mf_nibble_capture`

## Requirements
- R1: status[7:4] holds the captured nibble with status[7] as MSB. Frame index 0 is the frame strobed together with `mf_start`. The channel bit of frame 0 lands in status[7], and the bits of frames 5, 10 and 15 land in status[6], status[5] and status[4].
- R2: status[7:3] change only in the cycle after the frame strobe of the last frame of a multiframe (index 19), and only if `mf_en` is 1 in that cycle.
- R3: Until the first `mf_start` after reset, frame strobes cause no capture and no interrupt.
- R4: In network mode (`nt_mode`=1), status[3] after a capture is 1 exactly when `rx_bit` was 0 in all 16 frames of that multiframe whose index is not a multiple of 5. In terminal mode, status[3] is 0.
- R5: When `irq_every_mf`=1, every capture sets the pending interrupt. When it is 0, a capture sets it only if the new nibble differs from the nibble held before. status[2] mirrors `irq_every_mf`, and status[1:0] read 0.
- R6: A capture sets the pending interrupt only while `irq_en`=1 and `mf_en`=1.
- R7: `irq` is the pending flag. A `rd_stb` pulse clears it in the next cycle, unless a capture sets it in that same cycle; in that case the set wins.
- R8: While `rst_n`=0, or while `soft_rst`=1, the nibble goes to 4'b1111 in network mode and to 4'b0000 in terminal mode. The quality flag and `irq` go to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| soft_rst | input | 1 | Synchronous software reset, active high |
| nt_mode | input | 1 | 1 = network side, 0 = terminal side |
| mf_en | input | 1 | Multiframing enabled |
| irq_en | input | 1 | Multiframe interrupt enable |
| irq_every_mf | input | 1 | Interrupt policy: 1 = each multiframe, 0 = on changed nibble |
| frame_stb | input | 1 | One-cycle strobe per received frame |
| mf_start | input | 1 | With frame_stb: this frame is index 0 of a multiframe |
| rx_bit | input | 1 | Received channel/Fa bit of the strobed frame |
| rd_stb | input | 1 | Status word read strobe |
| status | output | 8 | {nibble, quality, policy, 2'b00} |
| irq | output | 1 | Interrupt request |

## Verification
The bench sends a full multiframe with the same nibble as the one held, under both interrupt policies. A design that compares against the wrong value would fire, or stay silent, on the wrong policy. A single 1 injected into one non-channel frame must clear the quality flag, which catches an accumulator that misses a frame or restarts too late. The bench sends 20 frames before any start strobe and checks the register just before the last frame of a multiframe, so a premature or unaligned capture shows up as a corrupted nibble. Captures with `mf_en` or `irq_en` low and resets in both modes expose gating and reset values that are wrong.

// File: rtl/mfcap_pkg.sv
// Shared types for the multiframe nibble capture block.
// Assumes a multiframe of NIB_W groups of GRP frames each.
package mfcap_pkg;

    // Position of the currently strobed frame inside the multiframe
    typedef struct packed {
        logic active;      // multiframe alignment has been seen
        logic first_frame; // index 0
        logic q_frame;     // index is a multiple of GRP (carries a channel bit)
        logic last_frame;  // index NIB_W*GRP-1
    } frame_pos_t;

endpackage

// File: rtl/mfcap_frame_tracker.sv
// Frame index tracker: counts frame strobes inside a multiframe,
// realigns to index 0 on every start strobe, and classifies the
// current frame. Assumes mf_start is only meaningful with frame_stb.
module mfcap_frame_tracker
    import mfcap_pkg::*;
#(
    parameter int NIB_W = 4,
    parameter int GRP   = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       soft_rst,
    input  logic       frame_stb,
    input  logic       mf_start,
    output frame_pos_t pos
);
    localparam int MF_LEN = NIB_W * GRP;
    localparam int IW     = $clog2(MF_LEN);

    logic [IW-1:0] idx_q;
    logic [IW-1:0] idx_cur;
    logic          synced_q;

    // Index of the frame being strobed now (start strobe forces 0)
    always_comb begin
        idx_cur         = mf_start ? '0 : idx_q;
        pos.active      = mf_start || synced_q;
        pos.first_frame = (idx_cur == '0);
        pos.q_frame     = ((int'(idx_cur) % GRP) == 0);
        pos.last_frame  = (int'(idx_cur) == MF_LEN - 1);
    end

    // Advance the index on each frame strobe once aligned
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            idx_q    <= '0;
            synced_q <= 1'b0;
        end else if (frame_stb && pos.active) begin
            synced_q <= 1'b1;
            idx_q    <= pos.last_frame ? '0 : idx_cur + IW'(1);
        end
    end

    AST_IDX_WRAP: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
        (frame_stb && pos.active && pos.last_frame) |=> (idx_q == '0)) else $error("idx wrap"); // R2

    AST_NO_SYNC_HOLD: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
        (!synced_q && !mf_start) |=> (idx_q == '0)) else $error("idx moved unsynced"); // R3
endmodule

// File: rtl/mfcap_collector.sv
// Channel bit collector: shifts the channel bit of each group-leading
// frame into a nibble (first bit ends as MSB), accumulates the Fa bits
// of the other frames, and commits both at the last frame.
// Assumes GRP >= 2 so the last frame carries no channel bit.
module mfcap_collector
    import mfcap_pkg::*;
#(
    parameter int NIB_W = 4,
    parameter int GRP   = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst,
    input  logic             nt_mode,
    input  logic             mf_en,
    input  logic             frame_stb,
    input  logic             rx_bit,
    input  frame_pos_t       pos,
    output logic [NIB_W-1:0] nibble,
    output logic             quality,
    output logic             commit,
    output logic             changed
);
    logic [NIB_W-1:0] shift_q;
    logic [NIB_W-1:0] nib_q;
    logic             acc_q;
    logic             qual_q;

    // Capture condition and change detection for the interrupt policy
    always_comb begin
        commit  = frame_stb && pos.active && pos.last_frame && mf_en;
        changed = (shift_q != nib_q);
    end

    // Shift channel bits and OR the non-channel Fa bits per multiframe
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            shift_q <= '0;
            acc_q   <= 1'b0;
        end else if (frame_stb && pos.active) begin
            if (pos.q_frame) begin
                shift_q <= {shift_q[NIB_W-2:0], rx_bit};
                if (pos.first_frame) acc_q <= 1'b0;
            end else begin
                acc_q <= acc_q | rx_bit;
            end
        end
    end

    // Commit nibble and quality flag at the end of the multiframe
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            nib_q  <= {NIB_W{nt_mode}};
            qual_q <= 1'b0;
        end else if (commit) begin
            nib_q  <= shift_q;
            qual_q <= nt_mode && !(acc_q || rx_bit);
        end
    end

    assign nibble  = nib_q;
    assign quality = qual_q;

    AST_NIB_HOLD: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
        ($past(rst_n) && !$past(soft_rst) && !$past(commit)) |-> ($stable(nib_q) && $stable(qual_q))) else $error("nibble moved"); // R2

    AST_TE_QUAL_ZERO: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
        (commit && !nt_mode) |=> !qual_q) else $error("quality in terminal mode"); // R4
endmodule

// File: rtl/mfcap_irq_ctrl.sv
// Interrupt control: sets a pending flag on a capture according to the
// policy and enables, and clears it on a status read (set wins).
// Assumes commit already includes the multiframing enable.
module mfcap_irq_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic soft_rst,
    input  logic commit,
    input  logic changed,
    input  logic every_mf,
    input  logic irq_en,
    input  logic mf_en,
    input  logic rd_stb,
    output logic irq
);
    logic set;
    logic pend_q;

    // Interrupt trigger per capture
    always_comb set = commit && mf_en && irq_en && (every_mf || changed);

    // Pending flag: set has priority over the read clear
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) pend_q <= 1'b0;
        else if (set)           pend_q <= 1'b1;
        else if (rd_stb)        pend_q <= 1'b0;
    end

    assign irq = pend_q;

    AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
        $rose(pend_q) |-> $past(irq_en && mf_en && commit)) else $error("irq without enable"); // R6

    AST_RD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
        (rd_stb && !set) |=> !pend_q) else $error("read did not clear"); // R7

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
        set |=> pend_q) else $error("set lost"); // R5
endmodule

// File: rtl/mf_nibble_capture.sv
// Top level: multiframe channel nibble capture with quality flag and
// maskable interrupt. Assumes upstream delivers aligned frame strobes.
module mf_nibble_capture #(
    parameter int NIB_W = 4,
    parameter int GRP   = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       soft_rst,
    input  logic       nt_mode,
    input  logic       mf_en,
    input  logic       irq_en,
    input  logic       irq_every_mf,
    input  logic       frame_stb,
    input  logic       mf_start,
    input  logic       rx_bit,
    input  logic       rd_stb,
    output logic [7:0] status,
    output logic       irq
);
    import mfcap_pkg::*;

    frame_pos_t       pos;
    logic [NIB_W-1:0] nibble;
    logic             quality;
    logic             commit;
    logic             changed;

    mfcap_frame_tracker #(.NIB_W(NIB_W), .GRP(GRP)) u_trk (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
        .frame_stb(frame_stb), .mf_start(mf_start), .pos(pos)
    );

    mfcap_collector #(.NIB_W(NIB_W), .GRP(GRP)) u_col (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .nt_mode(nt_mode),
        .mf_en(mf_en), .frame_stb(frame_stb), .rx_bit(rx_bit), .pos(pos),
        .nibble(nibble), .quality(quality), .commit(commit), .changed(changed)
    );

    mfcap_irq_ctrl u_irq (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .commit(commit),
        .changed(changed), .every_mf(irq_every_mf), .irq_en(irq_en),
        .mf_en(mf_en), .rd_stb(rd_stb), .irq(irq)
    );

    // Status word layout: nibble, quality, policy echo, zero pad
    always_comb status = {nibble, quality, irq_every_mf, 2'b00};

    AST_RESET_CLEAR: assert property (@(posedge clk)
        (!rst_n || soft_rst) |=> (!irq && !status[3])) else $error("reset state"); // R8
endmodule

// File: tb/tb_mf_nibble_capture.sv
module tb_mf_nibble_capture;
    logic clk = 0, rst_n = 0, soft_rst = 0, nt_mode = 1, mf_en = 1;
    logic irq_en = 1, irq_every_mf = 0, frame_stb = 0, mf_start = 0;
    logic rx_bit = 0, rd_stb = 0;
    logic [7:0] status;
    logic irq;
    int checks = 0, errors = 0;

    always #5 clk = ~clk;

    mf_nibble_capture dut (.*);

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic do_reset(input logic nt);
        @(negedge clk);
        rst_n = 0; nt_mode = nt;
        repeat (3) @(negedge clk);
        rst_n = 1;
    endtask

    task automatic send_frame(input logic b, input logic st);
        @(negedge clk);
        frame_stb = 1; rx_bit = b; mf_start = st;
        @(negedge clk);
        frame_stb = 0; rx_bit = 0; mf_start = 0;
    endtask

    // Sends frames 0..last_idx of a multiframe; bad_idx gets rx_bit=1
    task automatic send_mf(input logic [3:0] nib, input int bad_idx, input int last_idx);
        for (int i = 0; i <= last_idx; i++) begin
            if (i % 5 == 0) send_frame(nib[3 - i/5], i == 0);
            else            send_frame(i == bad_idx, 1'b0);
        end
    endtask

    task automatic pulse_rd();
        @(negedge clk); rd_stb = 1;
        @(negedge clk); rd_stb = 0;
    endtask

    task automatic t_reset_nt();
        do_reset(1);
        chk("R8 nt reset nibble", status[7:4], 4'hF);
        chk("R8 nt reset quality", status[3], 0);
        chk("R8 nt reset irq", irq, 0);
    endtask

    task automatic t_no_sync();
        for (int i = 0; i < 20; i++) send_frame(1'b0, 1'b0);
        chk("R3 no capture before start", status[7:4], 4'hF);
        chk("R3 no irq before start", irq, 0);
    endtask

    task automatic t_capture();
        send_mf(4'hA, -1, 18);
        chk("R2 no update before last frame", status[7:4], 4'hF);
        send_frame(1'b0, 1'b0);
        chk("R1 nibble order", status[7:4], 4'hA);
        chk("R4 quality clean", status[3], 1);
        chk("R5 irq on changed nibble", irq, 1);
        chk("R5 policy echo and pad", status[2:0], 0);
    endtask

    task automatic t_read_clear();
        pulse_rd();
        chk("R7 read clears irq", irq, 0);
    endtask

    task automatic t_same_nibble();
        send_mf(4'hA, 7, 19);
        chk("R4 bad Fa clears quality", status[3], 0);
        chk("R5 same nibble no irq", irq, 0);
        irq_every_mf = 1;
        send_mf(4'hA, -1, 19);
        chk("R5 every-multiframe irq", irq, 1);
        chk("R4 quality back to 1", status[3], 1);
        pulse_rd();
        irq_every_mf = 0;
    endtask

    task automatic t_gating();
        irq_en = 0;
        send_mf(4'h3, 19, 19);
        chk("R6 capture with irq_en low", status[7:4], 4'h3);
        chk("R4 bad last frame", status[3], 0);
        chk("R6 no irq when disabled", irq, 0);
        irq_en = 1; mf_en = 0;
        send_mf(4'hC, -1, 19);
        chk("R2 no capture with mf_en low", status[7:4], 4'h3);
        chk("R6 no irq with mf_en low", irq, 0);
        mf_en = 1;
    endtask

    task automatic t_soft_reset();
        send_mf(4'h6, -1, 19);
        chk("R1 nibble 6", status[7:4], 4'h6);
        @(negedge clk); soft_rst = 1;
        @(negedge clk); soft_rst = 0;
        chk("R8 soft reset nibble", status[7:4], 4'hF);
        chk("R8 soft reset irq", irq, 0);
    endtask

    task automatic t_terminal();
        do_reset(0);
        chk("R8 te reset nibble", status[7:4], 4'h0);
        send_mf(4'h5, -1, 19);
        chk("R1 te nibble", status[7:4], 4'h5);
        chk("R4 te quality zero", status[3], 0);
        chk("R5 te irq on change", irq, 1);
    endtask

    initial begin
        t_reset_nt();
        t_no_sync();
        t_capture();
        t_read_clear();
        t_same_nibble();
        t_gating();
        t_soft_reset();
        t_terminal();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule